// File: doc/BRIEF.md
# Exception entry and return controller

This block holds the privileged state of a 32-bit core: a status word, a cause word, and three saved return addresses (one for ordinary exceptions, one for error-level entries, one for debug entries). Each cycle it decides whether a pending hardware interrupt may be taken. When the core reports an exception, it computes the address to fetch from next, stores the return address and the branch-delay flag, and updates the level bits. The core signals an exception return or a debug return, and the block then sends the fetch back to the saved address.

The core drives the current PC, a flag that marks an instruction in a branch delay slot, an exception request with a kind and a 5-bit code, a qualifier that marks a translation-refill miss, eight interrupt lines, and register writes and reads. All outputs are registered. The outputs are a one-cycle redirect (valid plus address), the interrupt-take flag, the effective user-mode flag, a debug-mode flag, a coprocessor-0 fault flag, and a one-cycle pulse that clears the load-linked reservation.

Exception kind encoding on `exc_kind_i`: 0 general, 1 non-maskable interrupt, 2 soft reset, 3 debug. Register select encoding on `wr_sel_i`/`rd_sel_i`: 0 status, 1 cause, 2 saved PC, 3 error PC, 4 debug PC. Status bit positions: IE 0, EXL 1, ERL 2, UM 4, mask field 15:8, NMI 19, SR 20, BEV 22, CU0 28. Cause: BD 31, pending field 15:8, code 6:2.

Top module: `cp0_trap_ctrl`

## Requirements
- R1: While reset is high, redirect_valid_o is 1 with redirect_pc_o = 0xBFC00000. After reset the status reads 0x00400004 (BEV and ERL), and the debug-mode, user-mode and interrupt-take outputs are 0.
- R2: irq_take_o is 1 exactly when status IE is 1, EXL, ERL and debug mode are 0, and status[15:8] AND cause[15:8] is nonzero. The cause pending field follows irq_pending_i with one register stage.
- R3: A general exception (kind 0) taken with EXL clear stores PC in the saved PC and clears cause BD. If the delay-slot flag is set, it stores PC-4 and sets BD instead.
- R4: A general exception taken with EXL already set leaves the saved PC and cause BD unchanged.
- R5: A general exception redirects to base + offset. The base is 0xBFC00200 when BEV is 1 and 0x80000000 otherwise. The offset is 0x180 unless R6 applies.
- R6: The offset is 0x000 only when the refill qualifier is set, the code is 2 or 3, and EXL is clear. Otherwise it is 0x180.
- R7: A general exception writes its code into cause[6:2], sets status EXL, and keeps the other cause bits.
- R8: A non-maskable interrupt (kind 1) or soft reset (kind 2) stores PC (PC-4 from a delay slot) in the error PC, ORs ERL and BEV into status, plus NMI (bit 19) or SR (bit 20), and redirects to 0xBFC00000. The saved PC is left unchanged.
- R9: A debug exception (kind 3) stores PC (PC-4 from a delay slot) in the debug PC, sets debug mode and redirects to 0xBFC00480.
- R10: An exception return with ERL set redirects to the error PC and clears only ERL. With ERL clear it redirects to the saved PC and clears EXL. Both pulse ll_clear_o.
- R11: A debug return redirects to the debug PC, leaves debug mode and pulses ll_clear_o.
- R12: user_mode_o is 1 exactly when status UM is 1 and EXL, ERL and debug mode are 0. A coprocessor-0 access in user mode with CU0 = 0 sets cu_fault_o in the next cycle. Otherwise cu_fault_o stays 0.
- R13: A status write keeps only the bits of 0xF878FF17. A write to the cause register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | PC of the instruction taking the exception |
| in_delay_slot_i | input | 1 | Instruction sits in a branch delay slot |
| exc_req_i | input | 1 | Exception entry request |
| exc_kind_i | input | 2 | 0 general, 1 NMI, 2 soft reset, 3 debug |
| exc_code_i | input | 5 | Cause code for a general exception |
| tlb_refill_i | input | 1 | Miss was a translation refill |
| irq_pending_i | input | 8 | Interrupt request lines |
| ret_req_i | input | 1 | Exception return |
| dret_req_i | input | 1 | Debug return |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for write |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Register select for read |
| cp0_access_i | input | 1 | Core attempts a coprocessor-0 operation |
| rd_data_o | output | 32 | Registered read data |
| redirect_valid_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| irq_take_o | output | 1 | Pending interrupt may be taken |
| user_mode_o | output | 1 | Effective user mode |
| dbg_mode_o | output | 1 | Debug mode active |
| cu_fault_o | output | 1 | Coprocessor-unusable fault |
| ll_clear_o | output | 1 | Clear load-linked reservation |

## Verification
The bench sweeps every cause code against the refill qualifier, the delay-slot flag and BEV. A design that picked the refill offset for the wrong codes, or kept it while EXL is set, would send a fetch to the wrong vector. Each entry is followed by a nested exception. A design that let the nested entry overwrite the saved PC would return into the handler instead of the faulting code. The interrupt gate is swept over enable, level bits, masks and line patterns, so an interrupt taken at exception level would show up. The return paths are driven with both EXL and ERL set. A design that cleared both bits, or read the wrong return register, would resume at the wrong address.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int XLEN = 32;

  // status bit positions
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_UM  = 4;
  localparam int ST_NMI = 19;
  localparam int ST_SR  = 20;
  localparam int ST_BEV = 22;
  localparam int ST_CU0 = 28;

  // cause layout
  localparam int CA_BD       = 31;
  localparam int CA_CODE_LSB = 2;
  localparam int CODE_W      = 5;

  localparam logic [CODE_W-1:0] CODE_TLB_LOAD  = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLB_STORE = 5'd3;

  typedef enum logic [1:0] {
    EXC_GENERAL = 2'd0,
    EXC_NMI     = 2'd1,
    EXC_SOFTRST = 2'd2,
    EXC_DEBUG   = 2'd3
  } exc_kind_e;

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_CAUSE  = 3'd1,
    REG_EPC    = 3'd2,
    REG_ERREPC = 3'd3,
    REG_DEPC   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [XLEN-1:0] status;
    logic [XLEN-1:0] cause;
    logic [XLEN-1:0] epc;
    logic [XLEN-1:0] errorepc;
    logic [XLEN-1:0] depc;
    logic            dm;
  } priv_state_t;
endpackage

// File: rtl/cp0_mode_eval.sv
module cp0_mode_eval #(
  parameter int IRQ_N = 8
) (
  input  logic             ie,
  input  logic             exl,
  input  logic             erl,
  input  logic             um,
  input  logic             dm,
  input  logic [IRQ_N-1:0] im,
  input  logic [IRQ_N-1:0] ip,
  output logic             irq_take,
  output logic             user_eff
);
  logic [IRQ_N-1:0] hit;
  logic             quiet;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    assign hit[i] = im[i] & ip[i];
  end

  assign quiet    = ~exl & ~erl & ~dm;
  assign irq_take = ie & quiet & (|hit);
  assign user_eff = um & quiet;
endmodule

// File: rtl/cp0_trap_next.sv
module cp0_trap_next
  import cp0_pkg::*;
#(
  parameter int              IRQ_N        = 8,
  parameter int              IP_LSB       = 8,
  parameter int              INSN_BYTES   = 4,
  parameter logic [XLEN-1:0] RESET_VEC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BOOT_BASE    = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] RAM_BASE     = 32'h8000_0000,
  parameter logic [XLEN-1:0] DEBUG_VEC    = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] COMMON_OFS   = 32'h0000_0180,
  parameter logic [XLEN-1:0] REFILL_OFS   = 32'h0000_0000,
  parameter logic [XLEN-1:0] STATUS_WMASK = 32'hF878_FF17
) (
  input  priv_state_t       cur,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_ds_i,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              tlb_refill_i,
  input  logic [IRQ_N-1:0]  irq_i,
  input  logic              ret_req_i,
  input  logic              dret_req_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output priv_state_t       nxt,
  output logic              redir_v,
  output logic [XLEN-1:0]   redir_pc,
  output logic              ll_clr
);
  logic [XLEN-1:0] ret_addr;
  logic            refill_hit;
  logic [XLEN-1:0] gen_base;

  assign ret_addr   = in_ds_i ? (pc_i - INSN_BYTES[XLEN-1:0]) : pc_i;
  assign refill_hit = tlb_refill_i & ~cur.status[ST_EXL] &
                      ((exc_code_i == CODE_TLB_LOAD) || (exc_code_i == CODE_TLB_STORE));
  assign gen_base   = cur.status[ST_BEV] ? BOOT_BASE : RAM_BASE;

  always_comb begin
    nxt                       = cur;
    nxt.cause[IP_LSB +: IRQ_N] = irq_i;
    redir_v                   = 1'b0;
    redir_pc                  = RESET_VEC;
    ll_clr                    = 1'b0;
    if (exc_req_i) begin
      redir_v = 1'b1;
      case (exc_kind_e'(exc_kind_i))
        EXC_GENERAL: begin
          if (!cur.status[ST_EXL]) begin
            nxt.epc          = ret_addr;
            nxt.cause[CA_BD] = in_ds_i;
          end
          nxt.status[ST_EXL]                  = 1'b1;
          nxt.cause[CA_CODE_LSB +: CODE_W]    = exc_code_i;
          redir_pc = gen_base + (refill_hit ? REFILL_OFS : COMMON_OFS);
        end
        EXC_NMI, EXC_SOFTRST: begin
          nxt.errorepc       = ret_addr;
          nxt.status[ST_ERL] = 1'b1;
          nxt.status[ST_BEV] = 1'b1;
          if (exc_kind_e'(exc_kind_i) == EXC_NMI) nxt.status[ST_NMI] = 1'b1;
          else                                      nxt.status[ST_SR]  = 1'b1;
          redir_pc = RESET_VEC;
        end
        default: begin
          nxt.depc = ret_addr;
          nxt.dm   = 1'b1;
          redir_pc = DEBUG_VEC;
        end
      endcase
    end else if (ret_req_i) begin
      redir_v = 1'b1;
      ll_clr  = 1'b1;
      if (cur.status[ST_ERL]) begin
        redir_pc           = cur.errorepc;
        nxt.status[ST_ERL] = 1'b0;
      end else begin
        redir_pc           = cur.epc;
        nxt.status[ST_EXL] = 1'b0;
      end
    end else if (dret_req_i) begin
      redir_v  = 1'b1;
      ll_clr   = 1'b1;
      redir_pc = cur.depc;
      nxt.dm   = 1'b0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        REG_STATUS: nxt.status   = wr_data_i & STATUS_WMASK;
        REG_EPC:    nxt.epc      = wr_data_i;
        REG_ERREPC: nxt.errorepc = wr_data_i;
        REG_DEPC:   nxt.depc     = wr_data_i;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cp0_trap_ctrl.sv
module cp0_trap_ctrl
  import cp0_pkg::*;
#(
  parameter int              IRQ_N        = 8,
  parameter int              IP_LSB       = 8,
  parameter int              INSN_BYTES   = 4,
  parameter logic [XLEN-1:0] RESET_VEC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BOOT_BASE    = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] RAM_BASE     = 32'h8000_0000,
  parameter logic [XLEN-1:0] DEBUG_VEC    = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] COMMON_OFS   = 32'h0000_0180,
  parameter logic [XLEN-1:0] REFILL_OFS   = 32'h0000_0000,
  parameter logic [XLEN-1:0] STATUS_WMASK = 32'hF878_FF17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_delay_slot_i,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              tlb_refill_i,
  input  logic [IRQ_N-1:0]  irq_pending_i,
  input  logic              ret_req_i,
  input  logic              dret_req_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic [2:0]        rd_sel_i,
  input  logic              cp0_access_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              irq_take_o,
  output logic              user_mode_o,
  output logic              dbg_mode_o,
  output logic              cu_fault_o,
  output logic              ll_clear_o
);
  localparam logic [XLEN-1:0] STATUS_RST = (XLEN'(1) << ST_BEV) | (XLEN'(1) << ST_ERL);

  priv_state_t     st_q, st_nxt;
  logic            redir_v, ll_clr;
  logic [XLEN-1:0] redir_pc;
  logic            take_nxt, user_nxt, take_cur, user_cur;
  logic [XLEN-1:0] rd_mux;

  cp0_trap_next #(
    .IRQ_N(IRQ_N), .IP_LSB(IP_LSB), .INSN_BYTES(INSN_BYTES),
    .RESET_VEC(RESET_VEC), .BOOT_BASE(BOOT_BASE), .RAM_BASE(RAM_BASE),
    .DEBUG_VEC(DEBUG_VEC), .COMMON_OFS(COMMON_OFS), .REFILL_OFS(REFILL_OFS),
    .STATUS_WMASK(STATUS_WMASK)
  ) i_next (
    .cur(st_q), .pc_i(pc_i), .in_ds_i(in_delay_slot_i),
    .exc_req_i(exc_req_i), .exc_kind_i(exc_kind_i), .exc_code_i(exc_code_i),
    .tlb_refill_i(tlb_refill_i), .irq_i(irq_pending_i),
    .ret_req_i(ret_req_i), .dret_req_i(dret_req_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .nxt(st_nxt), .redir_v(redir_v), .redir_pc(redir_pc), .ll_clr(ll_clr)
  );

  // mode of the state being loaded: drives the registered mode outputs
  cp0_mode_eval #(.IRQ_N(IRQ_N)) i_mode_nxt (
    .ie(st_nxt.status[ST_IE]), .exl(st_nxt.status[ST_EXL]),
    .erl(st_nxt.status[ST_ERL]), .um(st_nxt.status[ST_UM]), .dm(st_nxt.dm),
    .im(st_nxt.status[IP_LSB +: IRQ_N]), .ip(st_nxt.cause[IP_LSB +: IRQ_N]),
    .irq_take(take_nxt), .user_eff(user_nxt)
  );

  // mode of the present state: judges a coprocessor-0 access made now
  cp0_mode_eval #(.IRQ_N(IRQ_N)) i_mode_cur (
    .ie(st_q.status[ST_IE]), .exl(st_q.status[ST_EXL]),
    .erl(st_q.status[ST_ERL]), .um(st_q.status[ST_UM]), .dm(st_q.dm),
    .im(st_q.status[IP_LSB +: IRQ_N]), .ip(st_q.cause[IP_LSB +: IRQ_N]),
    .irq_take(take_cur), .user_eff(user_cur)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel_i))
      REG_STATUS: rd_mux = st_q.status;
      REG_CAUSE:  rd_mux = st_q.cause;
      REG_EPC:    rd_mux = st_q.epc;
      REG_ERREPC: rd_mux = st_q.errorepc;
      REG_DEPC:   rd_mux = st_q.depc;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q             <= '{status: STATUS_RST, cause: '0, epc: '0,
                            errorepc: '0, depc: '0, dm: 1'b0};
      redirect_valid_o <= 1'b1;
      redirect_pc_o    <= RESET_VEC;
      irq_take_o       <= 1'b0;
      user_mode_o      <= 1'b0;
      dbg_mode_o       <= 1'b0;
      cu_fault_o       <= 1'b0;
      ll_clear_o       <= 1'b0;
      rd_data_o        <= '0;
    end else begin
      st_q             <= st_nxt;
      redirect_valid_o <= redir_v;
      redirect_pc_o    <= redir_pc;
      irq_take_o       <= take_nxt;
      user_mode_o      <= user_nxt;
      dbg_mode_o       <= st_nxt.dm;
      cu_fault_o       <= cp0_access_i & user_cur & ~st_q.status[ST_CU0];
      ll_clear_o       <= ll_clr;
      rd_data_o        <= rd_mux;
    end
  end

  logic unused_take_cur;
  assign unused_take_cur = take_cur;
endmodule

// File: rtl/cp0_trap_ctrl_chk.sv
module cp0_trap_ctrl_chk
  import cp0_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DEBUG_VEC    = 32'hBFC0_0480,
  parameter logic [XLEN-1:0] STATUS_WMASK = 32'hF878_FF17
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_req_i,
  input logic [1:0]        exc_kind_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic              ret_req_i,
  input logic [XLEN-1:0]   status_q,
  input logic              bd_q,
  input logic [CODE_W-1:0] code_q,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   errorepc_q,
  input logic              dm_q,
  input logic              irq_take_o,
  input logic              user_mode_o,
  input logic              dbg_mode_o,
  input logic              redirect_valid_o,
  input logic [XLEN-1:0]   redirect_pc_o
);
  // R2: interrupt never offered at exception, error or debug level
  a_r2_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |-> (status_q[ST_IE] && !status_q[ST_EXL] && !status_q[ST_ERL] && !dm_q));

  // R4: nested general exception keeps the saved PC and BD
  a_r4_nested_keep: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && exc_kind_i == 2'd0 && status_q[ST_EXL]) |=>
      ($stable(epc_q) && $stable(bd_q)));

  // R7: code field takes the request code, EXL set
  a_r7_code: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && exc_kind_i == 2'd0) |=>
      (code_q == $past(exc_code_i) && status_q[ST_EXL]));

  // R8: error-level entry sets ERL and BEV and goes to the reset vector
  a_r8_err_entry: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && (exc_kind_i == 2'd1 || exc_kind_i == 2'd2)) |=>
      (status_q[ST_ERL] && status_q[ST_BEV] && redirect_valid_o && redirect_pc_o == RESET_VEC));

  // R9: debug entry
  a_r9_dbg_entry: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && exc_kind_i == 2'd3) |=>
      (dbg_mode_o && redirect_valid_o && redirect_pc_o == DEBUG_VEC));

  // R10: return from error level uses the error PC and clears ERL
  a_r10_eret_erl: assert property (@(posedge clk) disable iff (rst)
    (ret_req_i && !exc_req_i && status_q[ST_ERL]) |=>
      (!status_q[ST_ERL] && redirect_pc_o == $past(errorepc_q)));

  // R12: user mode only with UM and no raised level
  a_r12_user: assert property (@(posedge clk) disable iff (rst)
    user_mode_o |-> (status_q[ST_UM] && !status_q[ST_EXL] && !status_q[ST_ERL] && !dbg_mode_o));

  // R13: no status bit outside the writable set is ever held
  a_r13_mask: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~STATUS_WMASK) == '0);
endmodule

bind cp0_trap_ctrl cp0_trap_ctrl_chk #(
  .RESET_VEC(RESET_VEC), .DEBUG_VEC(DEBUG_VEC), .STATUS_WMASK(STATUS_WMASK)
) i_chk (
  .clk(clk), .rst(rst), .exc_req_i(exc_req_i), .exc_kind_i(exc_kind_i),
  .exc_code_i(exc_code_i), .ret_req_i(ret_req_i),
  .status_q(st_q.status), .bd_q(st_q.cause[cp0_pkg::CA_BD]),
  .code_q(st_q.cause[cp0_pkg::CA_CODE_LSB +: cp0_pkg::CODE_W]),
  .epc_q(st_q.epc), .errorepc_q(st_q.errorepc), .dm_q(st_q.dm),
  .irq_take_o(irq_take_o), .user_mode_o(user_mode_o), .dbg_mode_o(dbg_mode_o),
  .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o)
);

// File: tb/test_cp0_trap_ctrl.sv
module test_cp0_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc;
  logic        in_ds, exc_req, tlb_refill, ret_req, dret_req, wr_en, cp0_access;
  logic [1:0]  exc_kind;
  logic [4:0]  exc_code;
  logic [7:0]  irq_lines;
  logic [2:0]  wr_sel, rd_sel;
  logic [31:0] wr_data;
  logic [31:0] rd_data, redirect_pc;
  logic        redirect_valid, irq_take, user_mode, dbg_mode, cu_fault, ll_clear;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  cp0_trap_ctrl i_cp0_trap_ctrl (
    .clk(clk), .rst(rst), .pc_i(pc), .in_delay_slot_i(in_ds),
    .exc_req_i(exc_req), .exc_kind_i(exc_kind), .exc_code_i(exc_code),
    .tlb_refill_i(tlb_refill), .irq_pending_i(irq_lines),
    .ret_req_i(ret_req), .dret_req_i(dret_req),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .cp0_access_i(cp0_access),
    .rd_data_o(rd_data), .redirect_valid_o(redirect_valid),
    .redirect_pc_o(redirect_pc), .irq_take_o(irq_take),
    .user_mode_o(user_mode), .dbg_mode_o(dbg_mode),
    .cu_fault_o(cu_fault), .ll_clear_o(ll_clear)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    rd_sel = sel;
    step();
    d = rd_data;
  endtask

  task automatic raise(input logic [1:0] kind, input logic [4:0] code,
                       input logic refill, input logic ds, input logic [31:0] at);
    exc_req = 1'b1; exc_kind = kind; exc_code = code;
    tlb_refill = refill; in_ds = ds; pc = at;
    step();
    exc_req = 1'b0; tlb_refill = 1'b0; in_ds = 1'b0;
  endtask

  task automatic do_ret();
    ret_req = 1'b1;
    step();
    ret_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, epc_exp, base, ofs;
    logic [7:0] im_pat [5];
    logic [7:0] irq_pat [5];
    im_pat  = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A};
    irq_pat = '{8'h00, 8'hA5, 8'h01, 8'h80, 8'hFF};
    rst = 1'b1; pc = '0; in_ds = 0; exc_req = 0; tlb_refill = 0; ret_req = 0;
    dret_req = 0; wr_en = 0; cp0_access = 0; exc_kind = 0; exc_code = 0;
    irq_lines = 0; wr_sel = 0; rd_sel = 0; wr_data = 0;
    repeat (3) step();
    chk("R1 redirect valid in reset", {31'd0, redirect_valid}, 32'd1);
    chk("R1 reset vector", redirect_pc, 32'hBFC0_0000);
    rst = 1'b0;
    step();
    rd(3'd0, v);  chk("R1 status after reset", v, 32'h0040_0004);
    chk("R1 debug mode", {31'd0, dbg_mode}, 32'd0);
    chk("R1 user mode", {31'd0, user_mode}, 32'd0);
    chk("R1 irq take", {31'd0, irq_take}, 32'd0);

    // R13 write mask and ignored cause write
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v);  chk("R13 status mask", v, 32'hF878_FF17);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v);  chk("R13 cause write ignored", v, 32'h0000_0000);

    // R2 interrupt gate sweep
    for (int lv = 0; lv < 8; lv++) begin
      for (int a = 0; a < 5; a++) begin
        for (int b = 0; b < 5; b++) begin
          irq_lines = irq_pat[b];
          wr(3'd0, {16'd0, im_pat[a], 5'd0, lv[2:0]});
          chk($sformatf("R2 gate lv=%0d im=%h ip=%h", lv, im_pat[a], irq_pat[b]),
              {31'd0, irq_take},
              {31'd0, lv[0] & ~lv[1] & ~lv[2] & (|(im_pat[a] & irq_pat[b]))});
        end
      end
    end
    irq_lines = 8'h00;
    wr(3'd0, 32'h0);

    // R3..R7, R10: general exception sweep with nested entry and return
    for (int bev = 0; bev < 2; bev++) begin
      for (int code = 0; code < 32; code++) begin
        for (int rf = 0; rf < 2; rf++) begin
          for (int ds = 0; ds < 2; ds++) begin
            wr(3'd0, 32'(bev) << 22);
            pc = 32'h0040_1000 + 32'(code) * 16 + 32'(rf) * 8;
            epc_exp = pc - 32'(ds) * 4;
            base = (bev != 0) ? 32'hBFC0_0200 : 32'h8000_0000;
            ofs  = (rf != 0 && (code == 2 || code == 3)) ? 32'h0 : 32'h180;
            raise(2'd0, 5'(code), rf[0], ds[0], pc);
            chk("R5 R6 vector", redirect_pc, base + ofs);
            chk("R5 redirect valid", {31'd0, redirect_valid}, 32'd1);
            rd(3'd2, v);  chk("R3 saved pc", v, epc_exp);
            rd(3'd1, v);  chk("R3 R7 cause", v, (32'(ds) << 31) | (32'(code) << 2));
            rd(3'd0, v);  chk("R7 status exl", v, (32'(bev) << 22) | 32'h2);
            raise(2'd0, 5'd2, 1'b1, ~ds[0], 32'h0000_7770);
            chk("R6 nested refill offset", redirect_pc, base + 32'h180);
            rd(3'd2, v);  chk("R4 saved pc kept", v, epc_exp);
            rd(3'd1, v);  chk("R4 R7 bd kept code new", v, (32'(ds) << 31) | 32'h8);
            do_ret();
            chk("R10 return to saved pc", redirect_pc, epc_exp);
            chk("R10 ll clear", {31'd0, ll_clear}, 32'd1);
            rd(3'd0, v);  chk("R10 exl cleared", v, 32'(bev) << 22);
          end
        end
      end
    end

    // R2 R9 R11 debug entry and return
    wr(3'd0, 32'h0000_FF01);
    irq_lines = 8'hFF;
    step();
    chk("R2 irq take enabled", {31'd0, irq_take}, 32'd1);
    raise(2'd3, 5'd0, 1'b0, 1'b1, 32'h1234_0010);
    chk("R9 debug vector", redirect_pc, 32'hBFC0_0480);
    chk("R9 debug mode", {31'd0, dbg_mode}, 32'd1);
    chk("R2 no irq in debug", {31'd0, irq_take}, 32'd0);
    rd(3'd4, v);  chk("R9 debug pc", v, 32'h1234_000C);
    dret_req = 1'b1; step(); dret_req = 1'b0;
    chk("R11 debug return", redirect_pc, 32'h1234_000C);
    chk("R11 ll clear", {31'd0, ll_clear}, 32'd1);
    chk("R11 left debug", {31'd0, dbg_mode}, 32'd0);
    chk("R2 irq after debug", {31'd0, irq_take}, 32'd1);
    irq_lines = 8'h00;

    // R8 NMI and soft reset
    wr(3'd2, 32'hCAFE_0000);
    wr(3'd0, 32'h1000_FF11);
    raise(2'd1, 5'd0, 1'b0, 1'b1, 32'h0040_2000);
    chk("R8 nmi vector", redirect_pc, 32'hBFC0_0000);
    chk("R12 no user at erl", {31'd0, user_mode}, 32'd0);
    rd(3'd3, v);  chk("R8 error pc", v, 32'h0040_1FFC);
    rd(3'd0, v);  chk("R8 nmi status", v, 32'h1048_FF15);
    rd(3'd2, v);  chk("R8 saved pc untouched", v, 32'hCAFE_0000);
    do_ret();
    chk("R10 return to error pc", redirect_pc, 32'h0040_1FFC);
    rd(3'd0, v);  chk("R10 erl cleared", v, 32'h1048_FF11);
    chk("R12 user after return", {31'd0, user_mode}, 32'd1);
    wr(3'd0, 32'h0000_0010);
    raise(2'd2, 5'd0, 1'b0, 1'b0, 32'h0040_3000);
    chk("R8 soft reset vector", redirect_pc, 32'hBFC0_0000);
    rd(3'd0, v);  chk("R8 soft reset status", v, 32'h0050_0014);
    rd(3'd3, v);  chk("R8 soft reset error pc", v, 32'h0040_3000);

    // R10 both levels set: ERL first, then EXL
    wr(3'd0, 32'h0000_0006);
    wr(3'd3, 32'h1111_0000);
    wr(3'd2, 32'h2222_0000);
    do_ret();
    chk("R10 erl priority", redirect_pc, 32'h1111_0000);
    rd(3'd0, v);  chk("R10 only erl cleared", v, 32'h0000_0002);
    do_ret();
    chk("R10 then saved pc", redirect_pc, 32'h2222_0000);
    rd(3'd0, v);  chk("R10 exl cleared", v, 32'h0000_0000);

    // R12 user mode and coprocessor-0 fault
    wr(3'd0, 32'h0000_0010);
    chk("R12 user mode", {31'd0, user_mode}, 32'd1);
    cp0_access = 1'b1; step(); cp0_access = 1'b0;
    chk("R12 fault without cu0", {31'd0, cu_fault}, 32'd1);
    step();
    chk("R12 fault one cycle", {31'd0, cu_fault}, 32'd0);
    wr(3'd0, 32'h1000_0010);
    cp0_access = 1'b1; step(); cp0_access = 1'b0;
    chk("R12 no fault with cu0", {31'd0, cu_fault}, 32'd0);
    wr(3'd0, 32'h0000_0012);
    chk("R12 no user at exl", {31'd0, user_mode}, 32'd0);
    cp0_access = 1'b1; step(); cp0_access = 1'b0;
    chk("R12 no fault at exl", {31'd0, cu_fault}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule